// File: doc/BRIEF.md
# Big-Endian Word/Halfword Data Memory

This block is the data store for a 32-bit processor core. It occupies a fixed window of the byte address space that starts at `BASE_ADDR` and is `DEPTH` words long. Inside the window, the byte at the lowest address of each word holds that word's most significant byte. The core reaches the memory through one port. Reads are combinational and writes are synchronous. Each access is either a full 32-bit word or a 16-bit halfword. Halfword loads come back zero-extended. A halfword store changes only the two bytes it addresses.

Two flags are decoded from the address and access size on every cycle. One reports a misaligned access and the other reports an address outside the window. When either flag is set, the read returns zero and a write does nothing. A separate debug port reads any stored word by index, so a test environment can dump memory contents without using the processor port.

Top module: `be_data_mem`

## Requirements
- R1: The byte address `BASE_ADDR + 4*k` selects word k, and consecutive words are 4 addresses apart. A word written at `BASE_ADDR + 4*k` appears on the debug port at index k.
- R2: A word access (`acc_half` = 0) at an aligned in-range address reads back all 32 bits exactly as written, including bit 31.
- R3: Bytes are stored big-endian. Byte offset 0 of a word holds bits [31:24]. A halfword with address bit 1 clear is bits [31:16] of the word, and a halfword with address bit 1 set is bits [15:0].
- R4: A halfword read (`acc_half` = 1) returns the selected 16 bits in `rd_data[15:0]`, with `rd_data[31:16]` at zero.
- R5: A halfword write stores `wr_data[15:0]` into the addressed halfword and leaves the other halfword of that word unchanged.
- R6: `misalign` is set for a word access whose address bits [1:0] are nonzero and for a halfword access whose address bit 0 is set. While `misalign` is set, `rd_data` is zero and a write changes no stored word.
- R7: `out_of_range` is set when the address is below `BASE_ADDR` or at or above `BASE_ADDR + 4*DEPTH`. While `out_of_range` is set, `rd_data` is zero and a write changes no stored word.
- R8: On a clock edge with `rst_n` low, every stored word is cleared to zero. Reset takes priority over a write issued in the same cycle.
- R9: `dbg_word` returns the word at `dbg_idx` combinationally, and returns zero when `dbg_idx` is `DEPTH` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a write takes effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the whole store |
| addr | input | 32 | Byte address of the access |
| acc_half | input | 1 | Access size: 0 selects a word, 1 selects a halfword |
| wr_en | input | 1 | Write request for the current access |
| wr_data | input | 32 | Store data; a halfword store uses bits [15:0] |
| rd_data | output | 32 | Load data, combinational from addr and acc_half |
| misalign | output | 1 | Misaligned access for the selected size |
| out_of_range | output | 1 | Address lies outside the data window |
| dbg_idx | input | IDX_W | Word index for the debug read |
| dbg_word | output | 32 | Stored word at dbg_idx, combinational |

## Verification
`rd_data`, `misalign`, `out_of_range` and `dbg_word` are combinational. They are due in the same cycle that the address, size or debug index changes. A write becomes visible only after the next rising edge. Each bench task therefore changes inputs on the falling edge and samples one time unit later. After a write, it reads back only on the falling edge that follows the committing rising edge. Reset clearing is checked on the first falling edge after a rising edge taken with `rst_n` low.

// File: rtl/dmem_pkg.sv
// Package: shared types for the big-endian data memory.
// Assumes: one access-size bit at the port (0 = word, 1 = halfword).
package dmem_pkg;
    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_HALF = 1'b1
    } acc_size_e;

    localparam int WORD_BITS = 32;
    localparam int HALF_BITS = 16;
    localparam int HALVES    = WORD_BITS / HALF_BITS;
endpackage

// File: rtl/dmem_decode.sv
// Module: dmem_decode
// Turns a byte address and access size into a word index, a halfword
// select and the two fault flags.
// Assumes: BASE_ADDR is word aligned and DEPTH >= 2.
module dmem_decode #(
    parameter logic [31:0] BASE_ADDR = 32'h1001_0000,
    parameter int          DEPTH     = 64,
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic [31:0]      addr,
    input  logic             acc_half,
    output logic [IDX_W-1:0] idx,
    output logic             half_low,
    output logic             misalign,
    output logic             out_of_range,
    output logic             access_ok
);
    logic [31:0] offset;
    logic        below_base;
    logic        past_end;

    // Offset from the base and window bounds.
    always_comb begin
        offset       = addr - BASE_ADDR;
        below_base   = (addr < BASE_ADDR);
        past_end     = ({2'b00, offset[31:2]} >= 32'(DEPTH));
        out_of_range = below_base || past_end;
    end

    // Alignment check depends on the access size.
    always_comb begin
        if (acc_half == dmem_pkg::ACC_HALF) misalign = addr[0];
        else                                misalign = |addr[1:0];
    end

    // Index, halfword select and overall permission.
    always_comb begin
        idx       = offset[IDX_W+1:2];
        half_low  = addr[1];
        access_ok = !misalign && !out_of_range;
    end
endmodule

// File: rtl/dmem_merge.sv
// Module: dmem_merge
// Builds the new stored word for a write: replaces either both halves
// (word store) or the addressed half (halfword store).
// Assumes: half_low = 1 picks the bits [15:0] half (big-endian order).
module dmem_merge (
    input  logic [31:0] old_word,
    input  logic [31:0] wr_data,
    input  logic        acc_half,
    input  logic        half_low,
    output logic [31:0] new_word
);
    for (genvar g = 0; g < dmem_pkg::HALVES; g++) begin : g_lane
        logic picked;
        // Lane g is written on a word store or when it is the addressed half.
        always_comb begin
            picked = (acc_half == dmem_pkg::ACC_WORD) || (half_low == (g == 0));
            if (!picked)
                new_word[16*g +: 16] = old_word[16*g +: 16];
            else if (acc_half == dmem_pkg::ACC_HALF)
                new_word[16*g +: 16] = wr_data[15:0];
            else
                new_word[16*g +: 16] = wr_data[16*g +: 16];
        end
    end
endmodule

// File: rtl/dmem_extract.sv
// Module: dmem_extract
// Forms the load result from a stored word: the full word, or one
// half zero-extended. It returns zero when the access is not allowed.
// Assumes: the caller supplies access_ok from the decoder.
module dmem_extract (
    input  logic [31:0] word,
    input  logic        acc_half,
    input  logic        half_low,
    input  logic        access_ok,
    output logic [31:0] rd_data
);
    // Select and zero-extend the result.
    always_comb begin
        if (!access_ok)
            rd_data = '0;
        else if (acc_half == dmem_pkg::ACC_WORD)
            rd_data = word;
        else if (half_low)
            rd_data = {16'h0000, word[15:0]};
        else
            rd_data = {16'h0000, word[31:16]};
    end
endmodule

// File: rtl/be_data_mem.sv
// Module: be_data_mem (top)
// Big-endian byte-addressed data memory with word and halfword access,
// a combinational read, a synchronous write and a debug word port.
// Assumes: single port; a fault flag vetoes the write; rst_n is synchronous.
module be_data_mem #(
    parameter logic [31:0] BASE_ADDR = 32'h1001_0000,
    parameter int          DEPTH     = 64,
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      addr,
    input  logic             acc_half,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    output logic             misalign,
    output logic             out_of_range,
    input  logic [IDX_W-1:0] dbg_idx,
    output logic [31:0]      dbg_word
);
    logic [31:0]      store [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             half_low;
    logic             access_ok;
    logic [31:0]      cur_word;
    logic [31:0]      next_word;

    dmem_decode #(.BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH)) u_dec (
        .addr(addr), .acc_half(acc_half), .idx(idx), .half_low(half_low),
        .misalign(misalign), .out_of_range(out_of_range), .access_ok(access_ok)
    );

    // Addressed word, guarded so a faulting index is never read.
    always_comb begin
        cur_word = access_ok ? store[idx] : '0;
    end

    dmem_merge u_mrg (
        .old_word(cur_word), .wr_data(wr_data), .acc_half(acc_half),
        .half_low(half_low), .new_word(next_word)
    );

    dmem_extract u_ext (
        .word(cur_word), .acc_half(acc_half), .half_low(half_low),
        .access_ok(access_ok), .rd_data(rd_data)
    );

    // Storage update: reset clears everything, else a permitted write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_en && access_ok) begin
            store[idx] <= next_word;
        end
    end

    // Debug read: indexes past the depth read as zero.
    always_comb begin
        dbg_word = (32'(dbg_idx) < 32'(DEPTH)) ? store[dbg_idx] : '0;
    end
endmodule

// File: rtl/dmem_checker.sv
// Module: dmem_checker
// Port-level properties of be_data_mem, attached by bind below.
// Assumes: observes only the top-level ports.
module dmem_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] addr,
    input logic        acc_half,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        misalign,
    input logic        out_of_range
);
    // A halfword load never carries upper bits.
    assert_half_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_half |-> rd_data[31:16] == 16'h0000);

    // A misaligned access reads zero.
    assert_misalign_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> rd_data == 32'h0);

    // An out-of-window access reads zero.
    assert_range_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> rd_data == 32'h0);

    // A permitted word store reads back unchanged at the same address.
    assert_word_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_half && !misalign && !out_of_range) |=>
        (!(addr == $past(addr) && !acc_half) || rd_data == $past(wr_data)));

    // A permitted halfword store reads back as its low 16 bits.
    assert_half_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_half && !misalign && !out_of_range) |=>
        (!(addr == $past(addr) && acc_half) ||
         rd_data == {16'h0000, $past(wr_data[15:0])}));
endmodule

bind be_data_mem dmem_checker u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .acc_half(acc_half),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .misalign(misalign), .out_of_range(out_of_range)
);

// File: tb/sim_be_data_mem.sv
// Bench: directed scenarios for be_data_mem, one task each.
module sim_be_data_mem;
    localparam int          CLK_P = 10;
    localparam logic [31:0] BASE  = 32'h1001_0000;
    localparam int          DEPTH = 64;
    localparam int          IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      addr = BASE;
    logic             acc_half = 1'b0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             misalign;
    logic             out_of_range;
    logic [IDX_W-1:0] dbg_idx = '0;
    logic [31:0]      dbg_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    be_data_mem #(.BASE_ADDR(BASE), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .acc_half(acc_half),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .misalign(misalign), .out_of_range(out_of_range),
        .dbg_idx(dbg_idx), .dbg_word(dbg_word)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one access; commits on the rising edge in between.
    task automatic do_write(logic [31:0] a, logic h, logic [31:0] d);
        @(negedge clk);
        addr = a; acc_half = h; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Set up a read and let the combinational path settle.
    task automatic look(logic [31:0] a, logic h);
        addr = a; acc_half = h;
        #1;
    endtask

    task automatic peek(int i);
        dbg_idx = IDX_W'(i);
        #1;
    endtask

    task automatic t_reset;
        peek(0);          check("R8 reset word0", dbg_word, 32'h0);
        peek(DEPTH-1);    check("R8 reset last", dbg_word, 32'h0);
        look(BASE, 1'b0); check("R8 reset read", rd_data, 32'h0);
        check("R6 aligned flag", {31'b0, misalign}, 32'h0);
        check("R7 in range flag", {31'b0, out_of_range}, 32'h0);
    endtask

    task automatic t_word;
        do_write(BASE, 1'b0, 32'h1234_5678);
        look(BASE, 1'b0); check("R2 word read", rd_data, 32'h1234_5678);
        do_write(BASE + 32'd20, 1'b0, 32'h8000_0001);
        look(BASE + 32'd20, 1'b0); check("R2 sign kept", rd_data, 32'h8000_0001);
        peek(5); check("R1 index 5", dbg_word, 32'h8000_0001);
        peek(0); check("R1 index 0", dbg_word, 32'h1234_5678);
        do_write(BASE + 32'(4*(DEPTH-1)), 1'b0, 32'hCAFE_F00D);
        look(BASE + 32'(4*(DEPTH-1)), 1'b0); check("R7 last in range", rd_data, 32'hCAFE_F00D);
    endtask

    task automatic t_endian;
        do_write(BASE + 32'd8, 1'b0, 32'hAABB_CCDD);
        look(BASE + 32'd8, 1'b1);  check("R3 R4 upper half", rd_data, 32'h0000_AABB);
        look(BASE + 32'd10, 1'b1); check("R3 R4 lower half", rd_data, 32'h0000_CCDD);
        check("R6 half at +2 aligned", {31'b0, misalign}, 32'h0);
    endtask

    task automatic t_half_store;
        do_write(BASE + 32'd8, 1'b1, 32'hFFFF_1234);
        peek(2); check("R5 upper store", dbg_word, 32'h1234_CCDD);
        do_write(BASE + 32'd10, 1'b1, 32'h9999_5678);
        peek(2); check("R5 lower store", dbg_word, 32'h1234_5678);
        look(BASE + 32'd10, 1'b1); check("R5 half read", rd_data, 32'h0000_5678);
    endtask

    task automatic t_misalign;
        @(negedge clk);
        look(BASE + 32'd1, 1'b0); check("R6 word +1 flag", {31'b0, misalign}, 32'h1);
        check("R6 misaligned read", rd_data, 32'h0);
        look(BASE + 32'd2, 1'b0); check("R6 word +2 flag", {31'b0, misalign}, 32'h1);
        look(BASE + 32'd3, 1'b1); check("R6 half +3 flag", {31'b0, misalign}, 32'h1);
        do_write(BASE + 32'd1, 1'b0, 32'hDEAD_BEEF);
        do_write(BASE + 32'd9, 1'b1, 32'hDEAD_BEEF);
        peek(0); check("R6 no word write", dbg_word, 32'h1234_5678);
        peek(2); check("R6 no half write", dbg_word, 32'h1234_5678);
    endtask

    task automatic t_range;
        @(negedge clk);
        look(BASE - 32'd4, 1'b0); check("R7 below flag", {31'b0, out_of_range}, 32'h1);
        check("R7 below read", rd_data, 32'h0);
        look(BASE + 32'(4*DEPTH), 1'b0); check("R7 above flag", {31'b0, out_of_range}, 32'h1);
        check("R7 above read", rd_data, 32'h0);
        do_write(BASE + 32'(4*DEPTH), 1'b0, 32'h5555_AAAA);
        do_write(BASE - 32'd4, 1'b0, 32'h5555_AAAA);
        peek(0);       check("R7 wrap word0", dbg_word, 32'h1234_5678);
        peek(DEPTH-1); check("R7 last unchanged", dbg_word, 32'hCAFE_F00D);
    endtask

    task automatic t_reset_prio;
        @(negedge clk);
        rst_n = 1'b0; addr = BASE + 32'd4; acc_half = 1'b0;
        wr_data = 32'h7777_7777; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b1;
        peek(1); check("R8 reset beats write", dbg_word, 32'h0);
        peek(0); check("R8 cleared word0", dbg_word, 32'h0);
        peek(DEPTH-1); check("R9 debug last", dbg_word, 32'h0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_endian();
        t_half_store();
        t_misalign();
        t_range();
        t_reset_prio();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule